// File: doc/BRIEF.md
# Counter-Based Jump Sequencer

This block is a small control sequencer whose state lives in a loadable 4-bit counter instead of a register fed by a full next-state table. In each cycle the counter does one of four things. It clears to zero, loads a target taken from a jump table, increments, or keeps its value. Three per-state condition selectors choose the step. Each selector picks, for the current state, one of eight boolean functions of the two condition inputs, and its result drives one of the counter's clear, load and count strobes.

The jump table, and the condition code that each selector uses in each state, are parameters. One block can therefore hold any sequence that follows this shape. The outputs are the current state, a one-hot decode of that state for the control logic that follows, and the three strobes, which also serve as control outputs.

Top module: `jc_controller`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0 after that edge. This holds whatever the condition inputs are.
- R2: If the clear strobe is high at an edge and `rst` is low, the state becomes 0.
- R3: If the load strobe is high and the clear strobe is low, the state becomes the jump-table entry of the current state. Entry s sits at bits [4s+3:4s] of `JUMP_TABLE`.
- R4: If only the count strobe is high, the state becomes the current state plus one.
- R5: Counting from state 15 gives state 0.
- R6: If no strobe is high, the state keeps its value.
- R7: Each strobe equals the condition code stored for the current state. The code for state s sits at bits [3s+2:3s] of its selector parameter. Codes are 0 = never, 1 = always, 2 = A, 3 = not A, 4 = B, 5 = not B, 6 = A and B, 7 = A or B.
- R8: `state_dec_o` has exactly one bit set, and that bit is the one whose index equals `state_o`.
- R9: If all three strobes are high together, clear wins. If load and count are high together, load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_a | input | 1 | Condition input A |
| cond_b | input | 1 | Condition input B |
| state_o | output | 4 | Current state |
| state_dec_o | output | 16 | One-hot decode of the state |
| clr_o | output | 1 | Clear strobe for the current state |
| ld_o | output | 1 | Load strobe for the current state |
| cnt_o | output | 1 | Count strobe for the current state |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that the condition inputs hold known, steady values at each rising edge, because each assertion compares the state after an edge with the strobes and jump target sampled at that edge. The stimulus starts in reset and changes `rst`, `cond_a` and `cond_b` only on falling edges. Reset pulses are occasional, and the condition inputs are random with a fixed seed, so the walk reaches the wrap state and the state where all three strobes fire at once.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        COND_NEVER   = 3'd0,
        COND_ALWAYS  = 3'd1,
        COND_A       = 3'd2,
        COND_NOT_A   = 3'd3,
        COND_B       = 3'd4,
        COND_NOT_B   = 3'd5,
        COND_A_AND_B = 3'd6,
        COND_A_OR_B  = 3'd7
    } cond_code_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic cnt;
    } step_ctrl_t;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_COUNT = 2'd1,
        STEP_LOAD  = 2'd2,
        STEP_CLEAR = 2'd3
    } step_kind_e;

    localparam logic [63:0] DEF_JUMP = 64'h0123456789ABCDEF;
    localparam logic [47:0] DEF_CLR  = 48'h000000000000;
    localparam logic [47:0] DEF_LD   = 48'h000000000000;
    localparam logic [47:0] DEF_CNT  = 48'h249249249249;

    function automatic logic eval_cond(cond_code_e code, logic a, logic b);
        logic r;
        case (code)
            COND_NEVER:   r = 1'b0;
            COND_ALWAYS:  r = 1'b1;
            COND_A:       r = a;
            COND_NOT_A:   r = ~a;
            COND_B:       r = b;
            COND_NOT_B:   r = ~b;
            COND_A_AND_B: r = a & b;
            default:      r = a | b;
        endcase
        return r;
    endfunction

    function automatic step_kind_e pick_step(step_ctrl_t c);
        step_kind_e k;
        if (c.clr)      k = STEP_CLEAR;
        else if (c.ld)  k = STEP_LOAD;
        else if (c.cnt) k = STEP_COUNT;
        else            k = STEP_HOLD;
        return k;
    endfunction

endpackage

// File: rtl/jc_cond_mux.sv
module jc_cond_mux
    import jc_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter logic [(2**STATE_W)*CODE_W-1:0] CODES = '0
) (
    input  logic [STATE_W-1:0] sel,
    input  logic               a,
    input  logic               b,
    output logic               hit
);
    localparam int NSTATES = 2**STATE_W;

    cond_code_e code;

    always_comb begin
        code = cond_code_e'(CODES[int'(sel)*CODE_W +: CODE_W]);
        hit  = eval_cond(code, a, b);
    end

endmodule

// File: rtl/jc_jump_rom.sv
module jc_jump_rom #(
    parameter int STATE_W = 4,
    parameter logic [(2**STATE_W)*STATE_W-1:0] TABLE = '0
) (
    input  logic [STATE_W-1:0] addr,
    output logic [STATE_W-1:0] data
);
    localparam int NSTATES = 2**STATE_W;

    logic [STATE_W-1:0] words [NSTATES];

    genvar gi;
    generate
        for (gi = 0; gi < NSTATES; gi++) begin : g_word
            assign words[gi] = TABLE[gi*STATE_W +: STATE_W];
        end
    endgenerate

    assign data = words[addr];

endmodule

// File: rtl/jc_state_counter.sv
module jc_state_counter
    import jc_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  step_ctrl_t         ctrl,
    input  logic [STATE_W-1:0] load_val,
    output logic [STATE_W-1:0] q
);
    step_kind_e kind;

    assign kind = pick_step(ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (kind)
                STEP_CLEAR: q <= '0;
                STEP_LOAD:  q <= load_val;
                STEP_COUNT: q <= q + 1'b1;
                default:    q <= q;
            endcase
        end
    end

    // R2: clear sends the state to zero
    a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl.clr |=> (q == '0));

    // R3: load without clear takes the jump target
    a_r3_load_target: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clr && ctrl.ld) |=> (q == $past(load_val)));

    // R4: count alone advances by one, R5 wraps naturally
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clr && !ctrl.ld && ctrl.cnt) |=> (q == STATE_W'($past(q) + 1'b1)));

    // R6: no strobe keeps the state
    a_r6_hold_state: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clr && !ctrl.ld && !ctrl.cnt) |=> $stable(q));

    // R9: clear beats both other strobes
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr && ctrl.ld && ctrl.cnt) |=> (q == '0));

endmodule

// File: rtl/jc_controller.sv
module jc_controller
    import jc_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter logic [(2**STATE_W)*STATE_W-1:0] JUMP_TABLE = DEF_JUMP,
    parameter logic [(2**STATE_W)*CODE_W-1:0]  CLR_CODES  = DEF_CLR,
    parameter logic [(2**STATE_W)*CODE_W-1:0]  LD_CODES   = DEF_LD,
    parameter logic [(2**STATE_W)*CODE_W-1:0]  CNT_CODES  = DEF_CNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cond_a,
    input  logic                    cond_b,
    output logic [STATE_W-1:0]      state_o,
    output logic [(2**STATE_W)-1:0] state_dec_o,
    output logic                    clr_o,
    output logic                    ld_o,
    output logic                    cnt_o
);
    localparam int NSTATES = 2**STATE_W;
    localparam int NSEL    = 3;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] jump_target;
    logic [NSEL-1:0]    strobes;
    step_ctrl_t         ctrl;

    genvar gs;
    generate
        for (gs = 0; gs < NSEL; gs++) begin : g_sel
            localparam logic [NSTATES*CODE_W-1:0] TBL =
                (gs == 0) ? CLR_CODES : (gs == 1) ? LD_CODES : CNT_CODES;
            jc_cond_mux #(
                .STATE_W (STATE_W),
                .CODES   (TBL)
            ) u_mux (
                .sel (state_q),
                .a   (cond_a),
                .b   (cond_b),
                .hit (strobes[gs])
            );
        end
    endgenerate

    assign ctrl.clr = strobes[0];
    assign ctrl.ld  = strobes[1];
    assign ctrl.cnt = strobes[2];

    jc_jump_rom #(
        .STATE_W (STATE_W),
        .TABLE   (JUMP_TABLE)
    ) u_rom (
        .addr (state_q),
        .data (jump_target)
    );

    jc_state_counter #(
        .STATE_W (STATE_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .load_val (jump_target),
        .q        (state_q)
    );

    genvar gd;
    generate
        for (gd = 0; gd < NSTATES; gd++) begin : g_dec
            assign state_dec_o[gd] = (state_q == STATE_W'(gd));
        end
    endgenerate

    assign state_o = state_q;
    assign clr_o   = ctrl.clr;
    assign ld_o    = ctrl.ld;
    assign cnt_o   = ctrl.cnt;

    // R8: decode is one-hot
    a_r8_onehot_decode: assert property (@(posedge clk) disable iff (rst)
        $countones(state_dec_o) == 1);

    // R1: reset brings the state to zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (1'b0)
        rst |=> (state_o == '0));

endmodule

// File: tb/sim_jc_controller.sv
module sim_jc_controller;
    import jc_pkg::*;

    function automatic logic [63:0] build_jump();
        logic [63:0] v = '0;
        for (int s = 0; s < 16; s++) v[s*4 +: 4] = 4'((s*5 + 11) % 16);
        return v;
    endfunction

    function automatic logic [2:0] clr_code(int s);
        return (s % 7 == 6) ? 3'd6 : 3'd0;
    endfunction
    function automatic logic [2:0] ld_code(int s);
        return (s == 6) ? 3'd4 : 3'((s*3 + 1) % 8);
    endfunction
    function automatic logic [2:0] cnt_code(int s);
        return (s == 6) ? 3'd2 : 3'((s*5 + 2) % 8);
    endfunction

    function automatic logic [47:0] build_codes(int which);
        logic [47:0] v = '0;
        for (int s = 0; s < 16; s++)
            v[s*3 +: 3] = (which == 0) ? clr_code(s) : (which == 1) ? ld_code(s) : cnt_code(s);
        return v;
    endfunction

    localparam logic [63:0] JT = build_jump();
    localparam logic [47:0] CC = build_codes(0);
    localparam logic [47:0] LC = build_codes(1);
    localparam logic [47:0] NC = build_codes(2);

    function automatic logic ref_cond(logic [2:0] c, logic a, logic b);
        case (c)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return a;
            3'd3: return !a;
            3'd4: return b;
            3'd5: return !b;
            3'd6: return a && b;
            default: return a || b;
        endcase
    endfunction

    logic        clk = 0;
    logic        rst = 1;
    logic        a = 0, b = 0;
    logic [3:0]  st;
    logic [15:0] dec;
    logic        c_o, l_o, n_o;

    int checks = 0, fails = 0;
    int cov[8];

    always #5 clk = ~clk;

    jc_controller #(
        .STATE_W(4), .JUMP_TABLE(JT), .CLR_CODES(CC), .LD_CODES(LC), .CNT_CODES(NC)
    ) u0 (
        .clk(clk), .rst(rst), .cond_a(a), .cond_b(b),
        .state_o(st), .state_dec_o(dec), .clr_o(c_o), .ld_o(l_o), .cnt_o(n_o)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] mq;
        logic [3:0] nq;
        string      tag;
        logic       ec, el, en;
        for (int k = 0; k < 8; k++) cov[k] = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(st == 4'd0, "R1 reset state", st, 0);
        check(dec == 16'h0001, "R8 reset decode", dec, 1);
        mq = 0;
        for (int i = 0; i < 8000; i++) begin
            rst = ($urandom % 60) == 0;
            a   = $urandom % 2;
            b   = $urandom % 2;
            #1;
            ec = ref_cond(clr_code(mq), a, b);
            el = ref_cond(ld_code(mq), a, b);
            en = ref_cond(cnt_code(mq), a, b);
            check({c_o, l_o, n_o} == {ec, el, en}, "R7 strobes", {c_o, l_o, n_o}, {ec, el, en});
            check(dec == (16'h1 << mq), "R8 decode", dec, 16'h1 << mq);
            if (rst) begin nq = 0; tag = "R1 reset"; cov[0]++; end
            else if (ec) begin
                nq = 0;
                if (el && en) begin tag = "R9 clear over load and count"; cov[6]++; end
                else begin tag = "R2 clear"; cov[1]++; end
            end else if (el) begin
                nq = JT[mq*4 +: 4];
                if (en) begin tag = "R9 load over count"; cov[7]++; end
                else begin tag = "R3 load"; cov[2]++; end
            end else if (en) begin
                nq = mq + 4'd1;
                if (mq == 4'd15) begin tag = "R5 wrap"; cov[4]++; end
                else begin tag = "R4 count"; cov[3]++; end
            end else begin nq = mq; tag = "R6 hold"; cov[5]++; end
            @(negedge clk);
            check(st == nq, tag, st, nq);
            mq = nq;
        end
        for (int k = 0; k < 8; k++)
            check(cov[k] > 0, "coverage of R1 R2 R3 R4 R5 R6 R9 cases", cov[k], 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule